// File: doc/BRIEF.md
# Two-Core Utility Monitor and Cache Way Allocator

This block watches the access stream of two cores that share a 16-way cache and decides how many ways each core should own. Each core has a private monitor that models a least-recently-used stack of tags for a thin, fixed sample of the cache sets (one set in every 32). A monitor counts how often an access hits at each recency depth of that stack, and how often it misses the whole stack. Because LRU is a stack algorithm, the hits at depths 0 to k-1 are exactly the hits that core would see if it owned k ways.

When the interval strobe arrives, the allocator scores every split that gives core 0 `a` ways and core 1 the remaining `16-a` ways. It adds the hits each core would keep under that split and registers the split with the highest total as the new quota. Every counter is then halved, so older behaviour keeps some weight but fades. The quota outputs drive a separate replacement stage that enforces the split. The data array and the victim choice are not part of this block.

Top module: `ucp_partitioner`

## Requirements
- R1: While reset is asserted and afterwards until the first interval strobe, each quota output reads 8 ways, and both miss-count outputs read 0.
- R2: An access updates a monitor only when the low 5 bits of its set index are zero. Other accesses change neither the shadow stacks nor any counter, so the miss count and later quotas are unaffected.
- R3: For a sampled access, a tag found at depth p (0 = MRU, 15 = LRU) moves to depth 0 while depths 0..p-1 each move one deeper, and the hit counter for depth p is incremented. A tag not found is placed at depth 0, all entries move one deeper, and the depth-15 entry is dropped.
- R4: A sampled access whose tag is not present at any valid depth increments that core's miss counter, visible on its miss-count output one cycle after the access.
- R5: `acc_core` selects the monitor. Core 0 accesses never change core 1's stacks or counters, and the reverse also holds.
- R6: On the cycle after an interval strobe, `quota_core0` equals the `a` in 1..15 that maximises (H0+…+H(a-1) of core 0) + (H0+…+H(15-a) of core 1), using the counters present before the strobe edge. `quota_core1` equals 16 minus `quota_core0`.
- R7: Among equally scored splits, the smallest `a` wins. With all counters zero, the strobe yields 1 way for core 0 and 15 for core 1.
- R8: At the strobe edge every hit and miss counter is replaced by half its value, rounded down. An access in the strobe cycle is counted first and then halved with the rest.
- R9: Every counter saturates at 2^CNT_W-1 and does not wrap.
- R10: Quotas change only on the cycle after an interval strobe and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_core | input | 1 | Core issuing the access (0 or 1) |
| acc_set | input | SET_W | Cache set index of the access |
| acc_tag | input | TAG_W | Tag of the access |
| interval_tick | input | 1 | End of a partitioning interval |
| quota_core0 | output | 5 | Ways allotted to core 0 |
| quota_core1 | output | 5 | Ways allotted to core 1 |
| miss_core0 | output | CNT_W | Shadow-stack miss count of core 0 |
| miss_core1 | output | CNT_W | Shadow-stack miss count of core 1 |

## Verification
A corrupted shadow stack shows up first as a wrong miss count, one cycle after the first access that reaches the damaged set. A wrong recency shift does not change the miss count. It shows only in the quota at the next strobe, when hits have been credited to the wrong depths, so the bench builds depth profiles that make a single depth decide the split. Errors in halving or saturation appear on the miss outputs on the cycle right after the strobe or after the overflowing access.

// File: rtl/ucp_pkg.sv
package ucp_pkg;
    localparam int WAYS  = 16;
    localparam int POS_W = $clog2(WAYS);

    typedef struct packed {
        logic             hit;
        logic             miss;
        logic [POS_W-1:0] pos;
    } ucp_evt_t;
endpackage

// File: rtl/ucp_shadow_dir.sv
module ucp_shadow_dir
    import ucp_pkg::*;
#(
    parameter int TAG_W       = 12,
    parameter int SET_W       = 10,
    parameter int SAMPLE_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [TAG_W-1:0] acc_tag,
    output ucp_evt_t         evt
);
    localparam int SH_W    = SET_W - SAMPLE_LOG2;
    localparam int SH_SETS = 1 << SH_W;
    localparam int ENT_W   = TAG_W + 1;

    typedef struct packed {
        logic [SH_SETS-1:0][WAYS-1:0][ENT_W-1:0] stk;
    } dir_st_t;

    dir_st_t           st_d, st_q;
    logic              sampled;
    logic [SH_W-1:0]   idx;
    logic              found;
    logic [POS_W-1:0]  pos;

    always_comb begin
        st_d    = st_q;
        sampled = acc_valid && (acc_set[SAMPLE_LOG2-1:0] == '0);
        idx     = acc_set[SET_W-1:SAMPLE_LOG2];
        found   = 1'b0;
        pos     = POS_W'(WAYS - 1);
        for (int w = 0; w < WAYS; w++) begin
            if (!found && st_q.stk[idx][w][TAG_W] &&
                st_q.stk[idx][w][TAG_W-1:0] == acc_tag) begin
                found = 1'b1;
                pos   = POS_W'(w);
            end
        end
        if (sampled) begin
            for (int w = 1; w < WAYS; w++) begin
                if (w <= int'(pos))
                    st_d.stk[idx][w] = st_q.stk[idx][w-1];
            end
            st_d.stk[idx][0] = {1'b1, acc_tag};
        end
        evt.hit  = sampled && found;
        evt.miss = sampled && !found;
        evt.pos  = pos;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the accessed tag sits at the MRU depth after a sampled access
    p_mru_insert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sampled |=> st_q.stk[$past(idx)][0] == {1'b1, $past(acc_tag)});

    // R2: accesses to unsampled sets leave the shadow stacks untouched
    p_unsampled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_set[SAMPLE_LOG2-1:0] != '0) |=> $stable(st_q));
endmodule

// File: rtl/ucp_util_counters.sv
module ucp_util_counters
    import ucp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  ucp_evt_t                   evt,
    input  logic                       tick,
    output logic [WAYS-1:0][CNT_W-1:0] hits,
    output logic [CNT_W-1:0]           misses
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [WAYS-1:0][CNT_W-1:0] hit_cnt;
        logic [CNT_W-1:0]           miss_cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt.hit && st_q.hit_cnt[evt.pos] != CNT_MAX)
            st_d.hit_cnt[evt.pos] = st_q.hit_cnt[evt.pos] + 1'b1;
        if (evt.miss && st_q.miss_cnt != CNT_MAX)
            st_d.miss_cnt = st_q.miss_cnt + 1'b1;
        if (tick) begin
            for (int k = 0; k < WAYS; k++)
                st_d.hit_cnt[k] = st_d.hit_cnt[k] >> 1;
            st_d.miss_cnt = st_d.miss_cnt >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hits   = st_q.hit_cnt;
    assign misses = st_q.miss_cnt;

    // R9: a full miss counter stays full under further misses
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (misses == CNT_MAX && evt.miss && !tick) |=> misses == CNT_MAX);

    // R8: after a strobe the miss count is at most half the old value plus one
    p_halve_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ({1'b0, misses} <= {2'b0, $past(misses[CNT_W-1:1])} + 1'b1));
endmodule

// File: rtl/ucp_way_alloc.sv
module ucp_way_alloc
    import ucp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [WAYS-1:0][CNT_W-1:0] hits0,
    input  logic [WAYS-1:0][CNT_W-1:0] hits1,
    output logic [POS_W:0]             quota0,
    output logic [POS_W:0]             quota1
);
    localparam int SUM_W   = CNT_W + POS_W + 1;
    localparam int SCORE_W = SUM_W + 1;

    typedef struct packed {
        logic [POS_W:0] q0;
        logic [POS_W:0] q1;
    } alloc_st_t;

    alloc_st_t          st_d, st_q;
    logic [SUM_W-1:0]   pre0 [0:WAYS];
    logic [SUM_W-1:0]   pre1 [0:WAYS];
    logic [SCORE_W-1:0] best_s, cand_s;
    logic [POS_W:0]     best_a;

    always_comb begin
        pre0[0] = '0;
        pre1[0] = '0;
        for (int k = 0; k < WAYS; k++) begin
            pre0[k+1] = pre0[k] + SUM_W'(hits0[k]);
            pre1[k+1] = pre1[k] + SUM_W'(hits1[k]);
        end
        best_a = (POS_W+1)'(1);
        best_s = SCORE_W'(pre0[1]) + SCORE_W'(pre1[WAYS-1]);
        cand_s = '0;
        for (int a = 2; a < WAYS; a++) begin
            cand_s = SCORE_W'(pre0[a]) + SCORE_W'(pre1[WAYS-a]);
            if (cand_s > best_s) begin
                best_s = cand_s;
                best_a = (POS_W+1)'(a);
            end
        end
        st_d = st_q;
        if (tick) begin
            st_d.q0 = best_a;
            st_d.q1 = (POS_W+1)'(WAYS) - best_a;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.q0 <= (POS_W+1)'(WAYS / 2);
            st_q.q1 <= (POS_W+1)'(WAYS / 2);
        end else begin
            st_q <= st_d;
        end
    end

    assign quota0 = st_q.q0;
    assign quota1 = st_q.q1;

    // R6: the two quotas always cover the full associativity
    p_quota_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ({1'b0, quota0} + {1'b0, quota1}) == (POS_W+2)'(WAYS));

    // R6: each core keeps at least one way
    p_quota_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (quota0 != '0 && quota1 != '0));

    // R10: quotas hold between strobes
    p_quota_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(quota0) && $stable(quota1)));
endmodule

// File: rtl/ucp_partitioner.sv
module ucp_partitioner
    import ucp_pkg::*;
#(
    parameter int TAG_W       = 12,
    parameter int SET_W       = 10,
    parameter int SAMPLE_LOG2 = 5,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_core,
    input  logic [SET_W-1:0] acc_set,
    input  logic [TAG_W-1:0] acc_tag,
    input  logic             interval_tick,
    output logic [POS_W:0]   quota_core0,
    output logic [POS_W:0]   quota_core1,
    output logic [CNT_W-1:0] miss_core0,
    output logic [CNT_W-1:0] miss_core1
);
    localparam int CORES = 2;

    logic [CORES-1:0][WAYS-1:0][CNT_W-1:0] hits_all;
    logic [CORES-1:0][CNT_W-1:0]           miss_all;

    for (genvar c = 0; c < CORES; c++) begin : g_mon
        ucp_evt_t evt;
        logic     sel;

        assign sel = acc_valid && (acc_core == 1'(c));

        ucp_shadow_dir #(
            .TAG_W(TAG_W), .SET_W(SET_W), .SAMPLE_LOG2(SAMPLE_LOG2)
        ) u_dir (
            .clk(clk), .rst_n(rst_n), .acc_valid(sel),
            .acc_set(acc_set), .acc_tag(acc_tag), .evt(evt)
        );

        ucp_util_counters #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .evt(evt), .tick(interval_tick),
            .hits(hits_all[c]), .misses(miss_all[c])
        );
    end

    ucp_way_alloc #(.CNT_W(CNT_W)) u_alloc (
        .clk(clk), .rst_n(rst_n), .tick(interval_tick),
        .hits0(hits_all[0]), .hits1(hits_all[1]),
        .quota0(quota_core0), .quota1(quota_core1)
    );

    assign miss_core0 = miss_all[0];
    assign miss_core1 = miss_all[1];
endmodule

// File: tb/tb_ucp_partitioner.sv
module tb_ucp_partitioner;
    localparam int TAG_W = 6, SET_W = 7, SLOG = 5, CNT_W = 6;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam int NSH   = 1 << (SET_W - SLOG);

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_core = 1'b0, interval_tick = 1'b0;
    logic [SET_W-1:0] acc_set = '0;
    logic [TAG_W-1:0] acc_tag = '0;
    logic [4:0] quota_core0, quota_core1;
    logic [CNT_W-1:0] miss_core0, miss_core1;

    always #2 clk = ~clk;

    ucp_partitioner #(.TAG_W(TAG_W), .SET_W(SET_W), .SAMPLE_LOG2(SLOG), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_core(acc_core),
        .acc_set(acc_set), .acc_tag(acc_tag), .interval_tick(interval_tick),
        .quota_core0(quota_core0), .quota_core1(quota_core1),
        .miss_core0(miss_core0), .miss_core1(miss_core1));

    // vector: [15] valid, [14] tick, [13] core, [12:6] set, [5:0] tag
    localparam int NV = 24;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,7'd0,6'd1},  {1'b1,1'b0,1'b0,7'd0,6'd2},
        {1'b1,1'b0,1'b0,7'd0,6'd3},  {1'b1,1'b0,1'b0,7'd0,6'd1},
        {1'b1,1'b0,1'b0,7'd0,6'd2},  {1'b1,1'b0,1'b0,7'd0,6'd3},
        {1'b1,1'b0,1'b0,7'd0,6'd1},  {1'b1,1'b0,1'b0,7'd0,6'd2},
        {1'b1,1'b0,1'b0,7'd0,6'd3},  {1'b1,1'b0,1'b1,7'd32,6'd5},
        {1'b1,1'b0,1'b1,7'd32,6'd5}, {1'b1,1'b0,1'b1,7'd32,6'd5},
        {1'b1,1'b0,1'b1,7'd32,6'd5}, {1'b1,1'b0,1'b0,7'd64,6'd9},
        {1'b1,1'b0,1'b1,7'd7,6'd1},  {1'b0,1'b1,1'b0,7'd0,6'd0},
        {1'b1,1'b0,1'b0,7'd0,6'd1},  {1'b1,1'b0,1'b0,7'd0,6'd2},
        {1'b1,1'b0,1'b0,7'd0,6'd3},  {1'b1,1'b0,1'b1,7'd96,6'd4},
        {1'b1,1'b0,1'b1,7'd96,6'd4}, {1'b1,1'b1,1'b0,7'd0,6'd4},
        {1'b1,1'b0,1'b1,7'd33,6'd5}, {1'b0,1'b1,1'b0,7'd0,6'd0}
    };

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    int m_tag [2][NSH][16];
    bit m_val [2][NSH][16];
    int m_hit [2][16];
    int m_miss[2];
    int m_q0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < 2; c++) begin
            m_miss[c] = 0;
            for (int k = 0; k < 16; k++) m_hit[c][k] = 0;
            for (int s = 0; s < NSH; s++)
                for (int k = 0; k < 16; k++) begin m_val[c][s][k] = 0; m_tag[c][s][k] = 0; end
        end
        m_q0 = 8;
    endtask

    task automatic model_step(bit v, bit tk, int core, int set, int tag);
        if (tk) begin
            int best = -1;
            for (int a = 1; a < 16; a++) begin
                int s = 0;
                for (int k = 0; k < a; k++) s += m_hit[0][k];
                for (int k = 0; k < 16 - a; k++) s += m_hit[1][k];
                if (s > best) begin best = s; m_q0 = a; end
            end
        end
        if (v && (set % 32) == 0) begin
            int ix = set / 32;
            int p = -1;
            for (int k = 0; k < 16; k++)
                if (p < 0 && m_val[core][ix][k] && m_tag[core][ix][k] == tag) p = k;
            if (p >= 0) begin
                if (m_hit[core][p] < CMAX) m_hit[core][p]++;
            end else begin
                if (m_miss[core] < CMAX) m_miss[core]++;
                p = 15;
            end
            for (int k = 15; k > 0; k--)
                if (k <= p) begin
                    m_tag[core][ix][k] = m_tag[core][ix][k-1];
                    m_val[core][ix][k] = m_val[core][ix][k-1];
                end
            m_tag[core][ix][0] = tag;
            m_val[core][ix][0] = 1;
        end
        if (tk) begin
            for (int c = 0; c < 2; c++) begin
                m_miss[c] = m_miss[c] / 2;
                for (int k = 0; k < 16; k++) m_hit[c][k] = m_hit[c][k] / 2;
            end
        end
    endtask

    task automatic step(bit v, bit tk, bit core, int set, int tag);
        @(negedge clk);
        acc_valid = v; interval_tick = tk; acc_core = core;
        acc_set = SET_W'(set); acc_tag = TAG_W'(tag);
        @(posedge clk); #1;
        model_step(v, tk, core, set, tag);
        @(negedge clk);
        acc_valid = 1'b0; interval_tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        acc_valid = 1'b0; interval_tick = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        model_clear();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 quota0", int'(quota_core0), 8);
        check("R1 quota1", int'(quota_core1), 8);
        check("R1 miss0", int'(miss_core0), 0);
        check("R1 miss1", int'(miss_core1), 0);

        // R2: an unsampled set is ignored
        step(1, 0, 0, 5, 3);
        check("R2 unsampled miss0", int'(miss_core0), 0);
        // R7: all-zero counters tie, smallest split wins
        step(0, 1, 0, 0, 0);
        check("R7 tie quota0", int'(quota_core0), 1);
        check("R7 tie quota1", int'(quota_core1), 15);

        // R3/R6: 15-tag loop makes every reuse hit at depth 14
        do_reset();
        for (int r = 0; r < 2; r++)
            for (int t = 0; t < 15; t++) step(1, 0, 0, 0, t);
        check("R4 miss0 count", int'(miss_core0), 15);
        check("R5 miss1 untouched", int'(miss_core1), 0);
        step(0, 1, 0, 0, 0);
        check("R3 depth14 quota0", int'(quota_core0), 15);
        check("R6 quota1", int'(quota_core1), 1);
        check("R8 halved miss0", int'(miss_core0), 7);

        // R9/R10: 17-tag loop always misses; counter saturates, quota holds
        do_reset();
        for (int i = 0; i < 70; i++) step(1, 0, 1, 32, i % 17);
        check("R9 saturated miss1", int'(miss_core1), CMAX);
        check("R10 quota held", int'(quota_core0), 8);

        // R8: access in the strobe cycle is counted before halving
        do_reset();
        for (int t = 0; t < 3; t++) step(1, 0, 0, 64, t);
        step(1, 1, 0, 64, 9);
        check("R8 strobe with access", int'(miss_core0), 2);

        // table walk against the requirement model
        do_reset();
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][15], VEC[i][14], VEC[i][13], int'(VEC[i][12:6]), int'(VEC[i][5:0]));
            check("R6 table quota0", int'(quota_core0), m_q0);
            check("R6 table quota1", int'(quota_core1), 16 - m_q0);
            check("R4 table miss0", int'(miss_core0), m_miss[0]);
            check("R5 table miss1", int'(miss_core1), m_miss[1]);
        end
        summary();
    end
endmodule